// File: doc/BRIEF.md
# Multicart outer bank translator

This block sits beside an MMC3-class inner mapper on a multigame cartridge and widens its bank numbers so that one menu can hand each game its own slice of a large PRG and CHR ROM. The CPU programs four 8-bit outer registers by writing to the $6000-$7FFF window. Address bits [1:0] pick the register. Every write in that window also goes on to the PRG-RAM path.

The inner mapper supplies its four 8 KB PRG window banks, its current 1 KB CHR bank and its R6 value. The block merges each inner bank with an outer value under an AND/OR mask. Two override modes are available. A fixed-PRG mode maps 16 KB or 32 KB from R6 in place of the per-window banks. A CNROM-like CHR mode builds the CHR bank from an outer register and the PPU address. A 4-bit switch value steps on every soft reset and can be read back in the ROM area, so a menu can tell soft resets apart. Bank outputs are combinational from the register state.

Top module: `mc_outer_bank`

## Requirements
- R1: A cycle with `cpu_we` high and `cpu_addr[15:13]`=3'b011 is a window write. While control bit 7 (register 0) is clear, a window write loads `cpu_wdata` into register `cpu_addr[1:0]` at that clock edge. Every window write raises `ram_we` in the same cycle, and no other write raises it.
- R2: While register 0 bit 7 is set, window writes to registers 0, 1 and 3 are ignored. A window write to register 2 replaces only its bits [1:0] and keeps bits [7:2].
- R3: For PRG, the mask is 0x0F when register 1 bit 2 is set and 0x1F otherwise. The outer value has register 1 bits [1:0] at bank bits [5:4] and register 0 bit 4 at bank bit 6. The result is (base & mask) | (outer & ~mask), 7 bits wide.
- R4: With register 1 bit 7 clear, the base of PRG window w (w=0..3, `inner_prg[w*8+:8]`, result at `prg_bank[w*7+:7]`) is that window's inner bank.
- R5: With register 1 bits 7 and 3 both set, the base of window w is R6 with bit 0 replaced by w[0] (windows 0,1,0,1).
- R6: With register 1 bit 7 set and bit 3 clear, the base of window w is R6 with bits [1:0] replaced by w (windows 0,1,2,3).
- R7: For CHR, the mask is 0x07F when register 1 bit 6 is set and 0x0FF otherwise. The outer value has register 1 bits [5:4] at bank bits [8:7] and register 0 bit 5 at bank bit 9. The same AND/OR rule applies and gives 10 bits.
- R8: With register 0 bit 3 set, the CHR base is {register 2, `ppu_a_hi`} (`ppu_a_hi` = PPU A12..A10) in place of `inner_chr`.
- R9: With register 0 bit 6 set and `cpu_addr[15]` high, `rd_override` is 1 and `rd_data` is {4'b0000, switch value}. Otherwise `rd_override` is 0.
- R10: `rst` (power-on) clears all four registers and the switch value to zero.
- R11: A `soft_rst` cycle clears all four registers and increments the switch value modulo 16. It takes precedence over a write in the same cycle.
- R12: A register write changes the bank outputs in the cycle that follows it, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| soft_rst | input | 1 | One-cycle soft reset strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| ppu_a_hi | input | 3 | PPU address bits A12..A10 |
| inner_prg | input | 32 | Inner 8 KB PRG banks, window w at [w*8+:8] |
| inner_r6 | input | 8 | Inner mapper R6 bank value |
| inner_chr | input | 8 | Inner 1 KB CHR bank for the current PPU access |
| prg_bank | output | 28 | Final PRG banks, window w at [w*7+:7] |
| chr_bank | output | 10 | Final 1 KB CHR bank |
| ram_we | output | 1 | PRG-RAM write pass-through |
| rd_override | output | 1 | Replace ROM read data with rd_data |
| rd_data | output | 8 | Override read data |

## Verification
A wrong register bit shows up on the very next cycle as a wrong high bit or a wrong mask boundary in `prg_bank` or `chr_bank`. The bench therefore compares every output right after each write. A lock that fails to hold, or that leaks into the other bits of register 2, changes the CNROM-mode CHR bank at once. A switch counter that misses a step or clears on soft reset only shows at the next override read. For that reason the bench reads the value back after each of seventeen soft resets, so that the wrap at 16 is also covered.

// File: rtl/mc_obt_pkg.sv
package mc_obt_pkg;
  localparam int OB_NUM_REG = 4;
  localparam int OB_REG_W   = 8;
  // register that stays partly writable while the lock bit is set
  localparam int OB_LOCK_EXEMPT = 2;
  // CPU address bits [15:13] of the register window
  localparam logic [2:0] OB_WIN_TAG = 3'b011;
  typedef logic [OB_REG_W-1:0] obreg_t;
endpackage

// File: rtl/mc_obt_regs.sv
module mc_obt_regs
  import mc_obt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIP_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           soft_rst,
  input  logic                           cpu_we,
  input  logic [ADDR_W-1:0]              cpu_addr,
  input  logic [DATA_W-1:0]              cpu_wdata,
  output logic [OB_NUM_REG*OB_REG_W-1:0] reg_flat,
  output logic [DIP_W-1:0]               dip_q,
  output logic                           ram_we
);
  localparam int SEL_W = $clog2(OB_NUM_REG);

  obreg_t            reg_q [OB_NUM_REG];
  logic              win_hit;
  logic [SEL_W-1:0]  sel;
  logic              locked;

  assign win_hit = cpu_we && (cpu_addr[ADDR_W-1 -: 3] == OB_WIN_TAG);
  assign sel     = cpu_addr[SEL_W-1:0];
  assign locked  = reg_q[0][7];
  assign ram_we  = win_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < OB_NUM_REG; i++) reg_q[i] <= '0;
      dip_q <= '0;
    end else if (soft_rst) begin
      for (int i = 0; i < OB_NUM_REG; i++) reg_q[i] <= '0;
      dip_q <= dip_q + 1'b1;
    end else if (win_hit) begin
      if (!locked)
        reg_q[sel] <= cpu_wdata[OB_REG_W-1:0];
      else if (sel == SEL_W'(OB_LOCK_EXEMPT))
        reg_q[OB_LOCK_EXEMPT][1:0] <= cpu_wdata[1:0];
    end
  end

  for (genvar g = 0; g < OB_NUM_REG; g++) begin : g_flat
    assign reg_flat[g*OB_REG_W +: OB_REG_W] = reg_q[g];
  end

  logic unused_addr;
  assign unused_addr = ^{cpu_addr[ADDR_W-4:SEL_W]};
endmodule

// File: rtl/mc_obt_prg_map.sv
module mc_obt_prg_map
  import mc_obt_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int PRG_IN_W  = 8,
  parameter int PRG_OUT_W = 7
) (
  input  obreg_t                         ctl0,
  input  obreg_t                         ctl1,
  input  logic [PRG_IN_W-1:0]            r6,
  input  logic [NUM_WIN*PRG_IN_W-1:0]    inner_prg,
  output logic [NUM_WIN*PRG_OUT_W-1:0]   prg_bank
);
  localparam logic [PRG_OUT_W-1:0] MASK_WIDE   = PRG_OUT_W'(8'h1F);
  localparam logic [PRG_OUT_W-1:0] MASK_NARROW = PRG_OUT_W'(8'h0F);

  logic [PRG_OUT_W-1:0] mask;
  logic [PRG_OUT_W-1:0] outer;

  always_comb begin
    mask     = ctl1[2] ? MASK_NARROW : MASK_WIDE;
    outer    = '0;
    outer[6] = ctl0[4];
    outer[5:4] = ctl1[1:0];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [1:0] WIDX = 2'(w);
    logic [PRG_IN_W-1:0]  fixed_base;
    logic [PRG_OUT_W-1:0] base;
    always_comb begin
      if (ctl1[3]) fixed_base = {r6[PRG_IN_W-1:1], WIDX[0]};
      else         fixed_base = {r6[PRG_IN_W-1:2], WIDX};
      if (ctl1[7]) base = PRG_OUT_W'(fixed_base);
      else         base = PRG_OUT_W'(inner_prg[w*PRG_IN_W +: PRG_IN_W]);
    end
    assign prg_bank[w*PRG_OUT_W +: PRG_OUT_W] = (base & mask) | (outer & ~mask);
  end
endmodule

// File: rtl/mc_obt_chr_map.sv
module mc_obt_chr_map
  import mc_obt_pkg::*;
#(
  parameter int CHR_IN_W  = 8,
  parameter int CHR_OUT_W = 10
) (
  input  obreg_t                 ctl0,
  input  obreg_t                 ctl1,
  input  obreg_t                 ctl2,
  input  logic [2:0]             ppu_a_hi,
  input  logic [CHR_IN_W-1:0]    inner_chr,
  output logic [CHR_OUT_W-1:0]   chr_bank
);
  localparam logic [CHR_OUT_W-1:0] MASK_WIDE   = CHR_OUT_W'(10'h0FF);
  localparam logic [CHR_OUT_W-1:0] MASK_NARROW = CHR_OUT_W'(10'h07F);

  logic [CHR_OUT_W-1:0] mask;
  logic [CHR_OUT_W-1:0] outer;
  logic [CHR_OUT_W-1:0] base;

  always_comb begin
    mask       = ctl1[6] ? MASK_NARROW : MASK_WIDE;
    outer      = '0;
    outer[9]   = ctl0[5];
    outer[8:7] = ctl1[5:4];
    if (ctl0[3]) base = CHR_OUT_W'({ctl2, ppu_a_hi});
    else         base = CHR_OUT_W'(inner_chr);
  end

  assign chr_bank = (base & mask) | (outer & ~mask);
endmodule

// File: rtl/mc_outer_bank.sv
module mc_outer_bank
  import mc_obt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NUM_WIN   = 4,
  parameter int PRG_IN_W  = 8,
  parameter int PRG_OUT_W = 7,
  parameter int CHR_IN_W  = 8,
  parameter int CHR_OUT_W = 10,
  parameter int DIP_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         soft_rst,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  input  logic                         cpu_we,
  input  logic [2:0]                   ppu_a_hi,
  input  logic [NUM_WIN*PRG_IN_W-1:0]  inner_prg,
  input  logic [PRG_IN_W-1:0]          inner_r6,
  input  logic [CHR_IN_W-1:0]          inner_chr,
  output logic [NUM_WIN*PRG_OUT_W-1:0] prg_bank,
  output logic [CHR_OUT_W-1:0]         chr_bank,
  output logic                         ram_we,
  output logic                         rd_override,
  output logic [DATA_W-1:0]            rd_data
);
  logic [OB_NUM_REG*OB_REG_W-1:0] reg_flat;
  logic [DIP_W-1:0]               dip_q;
  obreg_t ctl0, ctl1, ctl2;

  mc_obt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIP_W(DIP_W)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .reg_flat(reg_flat), .dip_q(dip_q), .ram_we(ram_we)
  );

  assign ctl0 = reg_flat[0*OB_REG_W +: OB_REG_W];
  assign ctl1 = reg_flat[1*OB_REG_W +: OB_REG_W];
  assign ctl2 = reg_flat[2*OB_REG_W +: OB_REG_W];

  mc_obt_prg_map #(.NUM_WIN(NUM_WIN), .PRG_IN_W(PRG_IN_W), .PRG_OUT_W(PRG_OUT_W)) u_prg (
    .ctl0(ctl0), .ctl1(ctl1), .r6(inner_r6),
    .inner_prg(inner_prg), .prg_bank(prg_bank)
  );

  mc_obt_chr_map #(.CHR_IN_W(CHR_IN_W), .CHR_OUT_W(CHR_OUT_W)) u_chr (
    .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2), .ppu_a_hi(ppu_a_hi),
    .inner_chr(inner_chr), .chr_bank(chr_bank)
  );

  // switch readback over the ROM area
  assign rd_override = ctl0[6] && cpu_addr[ADDR_W-1];
  assign rd_data     = DATA_W'(dip_q);

  logic unused_top;
  assign unused_top = ^{reg_flat[OB_NUM_REG*OB_REG_W-1:3*OB_REG_W], ctl0[2:0]};
endmodule

// File: rtl/mc_outer_bank_chk.sv
module mc_outer_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIP_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_we,
  input logic [2:0]        ppu_a_hi,
  input logic [27:0]       prg_bank,
  input logic [9:0]        chr_bank,
  input logic              ram_we,
  input logic              rd_override,
  input logic [DATA_W-1:0] rd_data,
  input logic [31:0]       regs,
  input logic [DIP_W-1:0]  dip
);
  logic wr_win;
  assign wr_win = cpu_we && (cpu_addr[ADDR_W-1 -: 3] == 3'b011);

  a_r1_ram_pass: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (cpu_we && cpu_addr[ADDR_W-1 -: 3] == 3'b011));

  a_r2_locked_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_win && regs[7] && cpu_addr[1:0] != 2'd2 && !soft_rst) |=> $stable(regs));

  a_r2_exempt_low: assert property (@(posedge clk) disable iff (rst)
    (wr_win && regs[7] && cpu_addr[1:0] == 2'd2 && !soft_rst) |=>
      (regs[23:18] == $past(regs[23:18]) && regs[17:16] == $past(cpu_wdata[1:0])));

  a_r5_nrom_pairs: assert property (@(posedge clk) disable iff (rst)
    (regs[15] && regs[11]) |-> (prg_bank[6:0] == prg_bank[20:14] &&
                                prg_bank[13:7] == prg_bank[27:21]));

  a_r8_cnrom_low: assert property (@(posedge clk) disable iff (rst)
    regs[3] |-> chr_bank[2:0] == ppu_a_hi);

  a_r9_dip_data: assert property (@(posedge clk) disable iff (rst)
    rd_override |-> rd_data == DATA_W'(dip));

  a_r11_dip_step: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> dip == DIP_W'($past(dip) + 1'b1));

  a_r11_regs_clear: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> regs == '0);
endmodule

bind mc_outer_bank mc_outer_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIP_W(DIP_W)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .ppu_a_hi(ppu_a_hi),
  .prg_bank(prg_bank), .chr_bank(chr_bank), .ram_we(ram_we),
  .rd_override(rd_override), .rd_data(rd_data),
  .regs(reg_flat), .dip(dip_q)
);

// File: tb/mc_outer_bank_bench.sv
module mc_outer_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        soft_rst = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [2:0]  ppu_a_hi = 3'd0;
  logic [31:0] inner_prg = 32'h0;
  logic [7:0]  inner_r6 = 8'h0;
  logic [7:0]  inner_chr = 8'h0;
  logic [27:0] prg_bank;
  logic [9:0]  chr_bank;
  logic        ram_we, rd_override;
  logic [7:0]  rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m [4];
  int mdip = 0;

  always #5 clk = ~clk;

  mc_outer_bank u_mc_outer_bank (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .ppu_a_hi(ppu_a_hi),
    .inner_prg(inner_prg), .inner_r6(inner_r6), .inner_chr(inner_chr),
    .prg_bank(prg_bank), .chr_bank(chr_bank), .ram_we(ram_we),
    .rd_override(rd_override), .rd_data(rd_data)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_prg(int w);
    int mask, outer, base;
    mask  = (m[1] & 4) ? 15 : 31;
    outer = ((m[1] & 3) << 4) | (((m[0] >> 4) & 1) << 6);
    if (m[1] & 128) base = (m[1] & 8) ? ((inner_r6 & ~1) | (w & 1)) : ((inner_r6 & ~3) | w);
    else            base = (inner_prg >> (w * 8)) & 255;
    return ((base & mask) | (outer & ~mask)) & 127;
  endfunction

  function automatic int exp_chr();
    int mask, outer, base;
    mask  = (m[1] & 64) ? 127 : 255;
    outer = (((m[1] >> 4) & 3) << 7) | (((m[0] >> 5) & 1) << 9);
    base  = (m[0] & 8) ? ((m[2] << 3) | ppu_a_hi) : inner_chr;
    return ((base & mask) | (outer & ~mask)) & 1023;
  endfunction

  task automatic check_banks(string req);
    #1;
    for (int w = 0; w < 4; w++) check(req, int'(prg_bank[w*7 +: 7]), exp_prg(w));
    check(req, int'(chr_bank), exp_chr());
  endtask

  // write with model update (R1, R2)
  task automatic wr(int addr, int data);
    int sel;
    bit hit;
    @(negedge clk);
    cpu_addr = 16'(addr); cpu_wdata = 8'(data); cpu_we = 1'b1;
    #1;
    hit = ((addr >> 13) & 7) == 3;
    check("R1 ram_we", int'(ram_we), int'(hit));
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 16'h0000;
    sel = addr & 3;
    if (hit) begin
      if (!(m[0] & 128)) m[sel] = data & 255;
      else if (sel == 2) m[2] = (m[2] & 252) | (data & 3);
    end
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    for (int i = 0; i < 4; i++) m[i] = 0;
    mdip = (mdip + 1) & 15;
  endtask

  task automatic check_dip(string req);
    wr(16'h6000, 8'h40);
    cpu_addr = 16'h8000; #1;
    check(req, int'(rd_override), 1);
    check(req, int'(rd_data), mdip);
    cpu_addr = 16'h7FFF; #1;
    check("R9 no override below ROM", int'(rd_override), 0);
    cpu_addr = 16'h0000;
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    inner_prg = 32'hF3_C2_A1_90; inner_chr = 8'hD7;
    check_banks("R10 reset banks");
    #1 check("R10 no override", int'(rd_override), 0);

    // R3 R4 R6 R5 R7 R8 R12 sweep
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 5; k++) begin
        int r0v;
        case (k)
          0: r0v = 8'h00; 1: r0v = 8'h18; 2: r0v = 8'h28; 3: r0v = 8'h38; default: r0v = 8'h08;
        endcase
        inner_r6  = 8'((a * 7 + 3 + k) & 255);
        inner_prg = {8'((a*13+111+k)&255), 8'((a*13+74+k)&255), 8'((a*13+37+k)&255), 8'((a*13+k)&255)};
        inner_chr = 8'((a * 29 + k * 5) & 255);
        ppu_a_hi  = 3'((a + k) & 7);
        wr(16'h6000, r0v);
        wr(16'h6002, (a ^ 8'h5A) & 255);
        wr(16'h7FFD, a);      // aliased register 1, R12: checked next cycle
        if (a & 128) check_banks((a & 8) ? "R5 nrom16" : "R6 nrom32");
        else if (r0v & 8) check_banks("R8 cnrom");
        else check_banks("R3 R4 R7 merge");
      end
    end

    // R1 writes outside the window are ignored
    wr(16'h6001, 8'h00);
    wr(16'h8001, 8'hFF);
    wr(16'h5FFF, 8'hFF);
    check_banks("R1 outside window");

    // R2 lock behaviour
    wr(16'h6001, 8'h11);
    wr(16'h6002, 8'hA4);
    wr(16'h6000, 8'h88);   // lock + CNROM
    ppu_a_hi = 3'd5;
    wr(16'h6001, 8'hFF);
    check_banks("R2 locked r1");
    wr(16'h6002, 8'hFF);
    check_banks("R2 r2 low bits");
    check(" R2 model r2", m[2], 8'hA7);
    wr(16'h6000, 8'h00);
    check_banks("R2 locked r0");
    wr(16'h6003, 8'h55);
    check_banks("R2 locked r3");

    // R11 soft reset, switch readback R9
    for (int s = 0; s < 17; s++) begin
      pulse_soft();
      check_banks("R11 cleared");
      check_dip("R9 R11 dip");
    end
    // R11 precedence over write
    @(negedge clk); soft_rst = 1'b1; cpu_we = 1'b1; cpu_addr = 16'h6001; cpu_wdata = 8'hFF;
    @(negedge clk); soft_rst = 1'b0; cpu_we = 1'b0; cpu_addr = 16'h0000;
    for (int i = 0; i < 4; i++) m[i] = 0;
    mdip = (mdip + 1) & 15;
    check_banks("R11 soft over write");
    check_dip("R11 dip step");

    // R10 power reset clears switch
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 4; i++) m[i] = 0;
    mdip = 0;
    check_banks("R10 power clear");
    check_dip("R10 dip zero");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule